// File: doc/BRIEF.md
# Circuit-Switched XY Mesh Routing Switch

This block is the routing switch of one node in a two-dimensional mesh network-on-chip that uses circuit switching. It has five ports (west, east, north, south and the local client). Every port has two control lanes in each direction. The forward lane carries messages from a route's source toward its destination. The backward lane carries messages the other way. The switch never carries payload. It sets up, confirms and tears down connections, and keeps a table of which input port currently owns which output port.

A route request carries a destination coordinate pair. The switch picks an output with dimension-ordered routing: first along x, then along y, then out to the local client. If the output is free, the switch reserves it and passes the request on. If the output is held, the switch answers with a kill on the backward lane of the port the request came in on, and buffers nothing. Acknowledges travel back along a reserved route, and releases travel forward along it. A release acknowledge or a kill travelling back frees the table entry at each switch it passes. All outputs are registered, so every message spends exactly one cycle in the switch. The node's own coordinates come from strap inputs.

Top module: `mesh_cs_router`

## Requirements
- R1: Header codes are NONE=0, REQ=1, ACK=2, REL=3, RELB=4 and KILL=5. The forward lane accepts only REQ and REL, and the backward lane accepts only ACK, RELB and KILL. Any other header on a valid lane is dropped and raises `err_o` for one cycle, one cycle later. Port indices are W=0, E=1, N=2, S=3, L=4. The forward destination field of port p is bits [p*6+5:p*6], with x in the upper 3 bits and y in the lower 3 bits.
- R2: The output is chosen from the strap coordinates `my_x_i`/`my_y_i` and the destination as follows. If dest x > own x, the output is E. If dest x < own x, it is W. Otherwise, if dest y > own y, it is N. If dest y < own y, it is S. Otherwise it is L.
- R3: A REQ whose output is free, and whose input holds no route, appears one cycle later on the forward lane of that output with the same destination, and the output becomes reserved for that input.
- R4: A REQ whose output is already reserved, including one being freed in the same cycle, is not forwarded. A KILL appears one cycle later on the backward lane of the port the REQ arrived on.
- R5: When several REQs target one free output in the same cycle, the lowest port index wins. Each of the others receives a KILL on its own backward lane one cycle later.
- R6: An ACK arriving on the backward lane of a reserved output appears one cycle later on the backward lane of the owning input, and the reservation is kept.
- R7: A REL arriving on the forward lane of an input that owns a route appears one cycle later on the forward lane of that route's output, with a zero destination field, and the reservation is kept.
- R8: A RELB arriving on the backward lane of a reserved output is passed to the owning input's backward lane one cycle later, and the output becomes free for later requests.
- R9: A KILL arriving on the backward lane of a reserved output is passed back and frees the entry in the same way as RELB.
- R10: A message that matches no entry is dropped with no output and raises `err_o` one cycle later. This covers REL on an input with no route, ACK/RELB/KILL on an unreserved output, and REQ on an input that already owns a route.
- R11: While reset is asserted, and after it, all outputs are zero and no output is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| my_x_i | input | 3 | Own x coordinate strap |
| my_y_i | input | 3 | Own y coordinate strap |
| fwd_vld_i | input | 5 | Forward-lane valid per port |
| fwd_hdr_i | input | 15 | Forward-lane header, 3 bits per port |
| fwd_dst_i | input | 30 | Forward-lane destination {x,y}, 6 bits per port |
| bwd_vld_i | input | 5 | Backward-lane valid per port |
| bwd_hdr_i | input | 15 | Backward-lane header, 3 bits per port |
| fwd_vld_o | output | 5 | Forward-lane valid out per port |
| fwd_hdr_o | output | 15 | Forward-lane header out |
| fwd_dst_o | output | 30 | Forward-lane destination out |
| bwd_vld_o | output | 5 | Backward-lane valid out per port |
| bwd_hdr_o | output | 15 | Backward-lane header out |
| err_o | output | 1 | One-cycle pulse for a dropped message |

## Verification
The bench targets four corner cases.

- Three requests racing for one output in the same cycle. A wrong tie-break would forward the wrong destination or kill the winner.
- A request arriving in the cycle a release acknowledge frees its output. A design that lets the release take effect early would forward the request onto a link still in use.
- A second request on an input that already owns a route. A design that does not check this would corrupt the table or answer with a kill that collides with the route's own backward traffic.
- Release and acknowledge traffic on ports with no matching entry. A design that is too lenient would emit stray messages instead of dropping them and flagging an error.

A vector table covers every routing direction, including exit to the local client, and tears down each route with a kill to show that entries are freed.

// File: rtl/mesh_cs_pkg.sv
package mesh_cs_pkg;
  localparam int NUM_PORTS = 5;
  localparam int PORT_W    = 3;
  localparam int HDR_W     = 3;

  typedef enum logic [HDR_W-1:0] {
    HDR_NONE = 3'd0,
    HDR_REQ  = 3'd1,
    HDR_ACK  = 3'd2,
    HDR_REL  = 3'd3,
    HDR_RELB = 3'd4,
    HDR_KILL = 3'd5
  } hdr_e;

  localparam logic [PORT_W-1:0] PORT_WEST  = 3'd0;
  localparam logic [PORT_W-1:0] PORT_EAST  = 3'd1;
  localparam logic [PORT_W-1:0] PORT_NORTH = 3'd2;
  localparam logic [PORT_W-1:0] PORT_SOUTH = 3'd3;
  localparam logic [PORT_W-1:0] PORT_LOCAL = 3'd4;
endpackage

// File: rtl/mesh_xy_route.sv
module mesh_xy_route
  import mesh_cs_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic [CW-1:0]     my_x_i,
  input  logic [CW-1:0]     my_y_i,
  input  logic [CW-1:0]     dst_x_i,
  input  logic [CW-1:0]     dst_y_i,
  output logic [PORT_W-1:0] port_o
);
  // x first, then y, then local exit
  always_comb begin
    if (dst_x_i > my_x_i)      port_o = PORT_EAST;
    else if (dst_x_i < my_x_i) port_o = PORT_WEST;
    else if (dst_y_i > my_y_i) port_o = PORT_NORTH;
    else if (dst_y_i < my_y_i) port_o = PORT_SOUTH;
    else                       port_o = PORT_LOCAL;
  end
endmodule

// File: rtl/mesh_out_arb.sv
module mesh_out_arb #(
  parameter int NP = 5
) (
  input  logic          busy_i,
  input  logic [NP-1:0] req_i,
  output logic [NP-1:0] gnt_o
);
  // lowest requesting index wins; nothing granted while held
  always_comb begin
    gnt_o = '0;
    if (!busy_i) begin
      for (int i = NP - 1; i >= 0; i--) begin
        if (req_i[i]) begin
          gnt_o    = '0;
          gnt_o[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mesh_route_table.sv
module mesh_route_table #(
  parameter int NP = 5,
  parameter int PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] set_i,
  input  logic [PW-1:0] set_src_i [NP],
  input  logic [NP-1:0] clr_i,
  output logic [NP-1:0] out_busy_o,
  output logic [PW-1:0] out_src_o [NP],
  output logic [NP-1:0] in_busy_o,
  output logic [PW-1:0] in_dst_o  [NP]
);
  logic [NP-1:0] busy_q;
  logic [PW-1:0] src_q [NP];

  // entries are keyed by output; set and clear never hit one entry together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      for (int o = 0; o < NP; o++) src_q[o] <= '0;
    end else begin
      for (int o = 0; o < NP; o++) begin
        if (set_i[o]) begin
          busy_q[o] <= 1'b1;
          src_q[o]  <= set_src_i[o];
        end else if (clr_i[o]) begin
          busy_q[o] <= 1'b0;
        end
      end
    end
  end

  // reverse view: which output does each input own
  always_comb begin
    in_busy_o = '0;
    for (int i = 0; i < NP; i++) in_dst_o[i] = '0;
    for (int i = 0; i < NP; i++) begin
      for (int o = 0; o < NP; o++) begin
        if (busy_q[o] && src_q[o] == PW'(i)) begin
          in_busy_o[i] = 1'b1;
          in_dst_o[i]  = PW'(o);
        end
      end
    end
  end

  assign out_busy_o = busy_q;
  assign out_src_o  = src_q;
endmodule

// File: rtl/mesh_cs_router.sv
module mesh_cs_router
  import mesh_cs_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [CW-1:0]               my_x_i,
  input  logic [CW-1:0]               my_y_i,
  input  logic [NUM_PORTS-1:0]        fwd_vld_i,
  input  logic [NUM_PORTS*HDR_W-1:0]  fwd_hdr_i,
  input  logic [NUM_PORTS*2*CW-1:0]   fwd_dst_i,
  input  logic [NUM_PORTS-1:0]        bwd_vld_i,
  input  logic [NUM_PORTS*HDR_W-1:0]  bwd_hdr_i,
  output logic [NUM_PORTS-1:0]        fwd_vld_o,
  output logic [NUM_PORTS*HDR_W-1:0]  fwd_hdr_o,
  output logic [NUM_PORTS*2*CW-1:0]   fwd_dst_o,
  output logic [NUM_PORTS-1:0]        bwd_vld_o,
  output logic [NUM_PORTS*HDR_W-1:0]  bwd_hdr_o,
  output logic                        err_o
);
  localparam int NP = NUM_PORTS;
  localparam int PW = PORT_W;
  localparam int HW = HDR_W;
  localparam int DW = 2 * CW;

  logic [PW-1:0] route [NP];
  logic [NP-1:0] f_req, f_rel, f_bad, b_ack, b_tear, b_bad;
  logic [NP-1:0] req_elig, won, kill_local;
  logic [NP-1:0] arb_req [NP];
  logic [NP-1:0] arb_gnt [NP];
  logic [NP-1:0] set_vec, clr_vec;
  logic [PW-1:0] set_src [NP];
  logic [NP-1:0] out_busy, in_busy;
  logic [PW-1:0] out_src [NP];
  logic [PW-1:0] in_dst  [NP];

  logic [NP-1:0]    fwd_vld_d, bwd_vld_d;
  logic [NP*HW-1:0] fwd_hdr_d, bwd_hdr_d;
  logic [NP*DW-1:0] fwd_dst_d;
  logic             err_d;

  for (genvar i = 0; i < NP; i++) begin : g_route
    mesh_xy_route #(.CW(CW)) u_route (
      .my_x_i (my_x_i),
      .my_y_i (my_y_i),
      .dst_x_i(fwd_dst_i[i*DW+CW +: CW]),
      .dst_y_i(fwd_dst_i[i*DW +: CW]),
      .port_o (route[i])
    );
  end

  // lane decode
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      f_req[i]  = fwd_vld_i[i] && fwd_hdr_i[i*HW +: HW] == HDR_REQ;
      f_rel[i]  = fwd_vld_i[i] && fwd_hdr_i[i*HW +: HW] == HDR_REL;
      f_bad[i]  = fwd_vld_i[i] && !f_req[i] && !f_rel[i];
      b_ack[i]  = bwd_vld_i[i] && bwd_hdr_i[i*HW +: HW] == HDR_ACK;
      b_tear[i] = bwd_vld_i[i] && (bwd_hdr_i[i*HW +: HW] == HDR_RELB ||
                                   bwd_hdr_i[i*HW +: HW] == HDR_KILL);
      b_bad[i]  = bwd_vld_i[i] && !b_ack[i] && !b_tear[i];
    end
  end

  assign req_elig = f_req & ~in_busy;

  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        arb_req[o][i] = req_elig[i] && route[i] == PW'(o);
  end

  for (genvar o = 0; o < NP; o++) begin : g_arb
    mesh_out_arb #(.NP(NP)) u_arb (
      .busy_i(out_busy[o]),
      .req_i (arb_req[o]),
      .gnt_o (arb_gnt[o])
    );
  end

  always_comb begin
    won = '0;
    for (int o = 0; o < NP; o++) begin
      set_vec[o] = |arb_gnt[o];
      set_src[o] = '0;
      clr_vec[o] = b_tear[o] && out_busy[o];
      for (int i = 0; i < NP; i++) begin
        if (arb_gnt[o][i]) begin
          set_src[o] = PW'(i);
          won[i]     = 1'b1;
        end
      end
    end
  end

  assign kill_local = req_elig & ~won;

  mesh_route_table #(.NP(NP), .PW(PW)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .set_src_i (set_src),
    .clr_i     (clr_vec),
    .out_busy_o(out_busy),
    .out_src_o (out_src),
    .in_busy_o (in_busy),
    .in_dst_o  (in_dst)
  );

  // next output messages; forward REQ needs a free output, REL a held one
  always_comb begin
    fwd_vld_d = '0;
    fwd_hdr_d = '0;
    fwd_dst_d = '0;
    bwd_vld_d = '0;
    bwd_hdr_d = '0;
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        if (arb_gnt[o][i]) begin
          fwd_vld_d[o]           = 1'b1;
          fwd_hdr_d[o*HW +: HW]  = HDR_REQ;
          fwd_dst_d[o*DW +: DW]  = fwd_dst_i[i*DW +: DW];
        end
        if (f_rel[i] && in_busy[i] && in_dst[i] == PW'(o)) begin
          fwd_vld_d[o]           = 1'b1;
          fwd_hdr_d[o*HW +: HW]  = HDR_REL;
        end
      end
    end
    for (int p = 0; p < NP; p++) begin
      if (kill_local[p]) begin
        bwd_vld_d[p]          = 1'b1;
        bwd_hdr_d[p*HW +: HW] = HDR_KILL;
      end
      for (int q = 0; q < NP; q++) begin
        if ((b_ack[q] || b_tear[q]) && out_busy[q] && out_src[q] == PW'(p)) begin
          bwd_vld_d[p]          = 1'b1;
          bwd_hdr_d[p*HW +: HW] = bwd_hdr_i[q*HW +: HW];
        end
      end
    end
    err_d = |(f_bad | (f_req & in_busy) | (f_rel & ~in_busy) | b_bad |
              ((b_ack | b_tear) & ~out_busy));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_vld_o <= '0;
      fwd_hdr_o <= '0;
      fwd_dst_o <= '0;
      bwd_vld_o <= '0;
      bwd_hdr_o <= '0;
      err_o     <= 1'b0;
    end else begin
      fwd_vld_o <= fwd_vld_d;
      fwd_hdr_o <= fwd_hdr_d;
      fwd_dst_o <= fwd_dst_d;
      bwd_vld_o <= bwd_vld_d;
      bwd_hdr_o <= bwd_hdr_d;
      err_o     <= err_d;
    end
  end
endmodule

// File: rtl/mesh_cs_router_chk.sv
module mesh_cs_router_chk
  import mesh_cs_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_PORTS-1:0]       fwd_vld_i,
  input logic [NUM_PORTS*HDR_W-1:0] fwd_hdr_i,
  input logic [NUM_PORTS-1:0]       bwd_vld_i,
  input logic [NUM_PORTS*HDR_W-1:0] bwd_hdr_i,
  input logic [NUM_PORTS-1:0]       fwd_vld_o,
  input logic [NUM_PORTS*HDR_W-1:0] fwd_hdr_o,
  input logic [NUM_PORTS-1:0]       bwd_vld_o,
  input logic [NUM_PORTS*HDR_W-1:0] bwd_hdr_o,
  input logic                       err_o,
  input logic [NUM_PORTS-1:0]       out_busy,
  input logic [PORT_W-1:0]          out_src [NUM_PORTS]
);
  localparam int NP = NUM_PORTS;
  localparam int HW = HDR_W;

  logic [NP-1:0] req_in;
  logic          any_req_in, any_rel_in, any_ack_in, any_kill_in, any_in;
  logic [NP-1:0] src_hits [NP];

  always_comb begin
    any_rel_in  = 1'b0;
    any_ack_in  = 1'b0;
    any_kill_in = 1'b0;
    for (int p = 0; p < NP; p++) begin
      req_in[p]   = fwd_vld_i[p] && fwd_hdr_i[p*HW +: HW] == HDR_REQ;
      any_rel_in  = any_rel_in  | (fwd_vld_i[p] && fwd_hdr_i[p*HW +: HW] == HDR_REL);
      any_ack_in  = any_ack_in  | (bwd_vld_i[p] && bwd_hdr_i[p*HW +: HW] == HDR_ACK);
      any_kill_in = any_kill_in | (bwd_vld_i[p] && bwd_hdr_i[p*HW +: HW] == HDR_KILL);
      for (int o = 0; o < NP; o++)
        src_hits[p][o] = out_busy[o] && out_src[o] == PORT_W'(p);
    end
    any_req_in = |req_in;
    any_in     = |fwd_vld_i || |bwd_vld_i;
  end

  for (genvar p = 0; p < NP; p++) begin : g_chk
    // R1
    fwd_lane_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fwd_vld_o[p] |-> (fwd_hdr_o[p*HW +: HW] == HDR_REQ || fwd_hdr_o[p*HW +: HW] == HDR_REL));
    // R1
    bwd_lane_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bwd_vld_o[p] |-> (bwd_hdr_o[p*HW +: HW] == HDR_ACK || bwd_hdr_o[p*HW +: HW] == HDR_RELB ||
                        bwd_hdr_o[p*HW +: HW] == HDR_KILL));
    // R3
    req_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fwd_vld_o[p] && fwd_hdr_o[p*HW +: HW] == HDR_REQ) |-> $past(any_req_in));
    // R4
    kill_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bwd_vld_o[p] && bwd_hdr_o[p*HW +: HW] == HDR_KILL) |-> ($past(req_in[p]) || $past(any_kill_in)));
    // R6
    ack_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bwd_vld_o[p] && bwd_hdr_o[p*HW +: HW] == HDR_ACK) |-> $past(any_ack_in));
    // R7
    rel_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fwd_vld_o[p] && fwd_hdr_o[p*HW +: HW] == HDR_REL) |-> $past(any_rel_in));
    // R3
    one_route_per_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(src_hits[p]) <= 1);
  end

  // R10
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(any_in));
endmodule

bind mesh_cs_router mesh_cs_router_chk u_chk (.*);

// File: tb/mesh_cs_router_tb.sv
module mesh_cs_router_tb;
  localparam int NP = 5;
  localparam logic [2:0] REQ = 3'd1, ACK = 3'd2, REL = 3'd3, RELB = 3'd4, KILL = 3'd5;
  localparam int W = 0, E = 1, N = 2, S = 3, L = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] my_x_i, my_y_i;
  logic [NP-1:0] fwd_vld_i, bwd_vld_i, fwd_vld_o, bwd_vld_o;
  logic [NP*3-1:0] fwd_hdr_i, bwd_hdr_i, fwd_hdr_o, bwd_hdr_o;
  logic [NP*6-1:0] fwd_dst_i, fwd_dst_o;
  logic err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  mesh_cs_router u_dut (.*);

  // {my_x, my_y, dst_x, dst_y, in_port, exp_out_port}
  localparam logic [17:0] VEC [8] = '{
    {3'd2, 3'd2, 3'd4, 3'd1, 3'd0, 3'd1},
    {3'd2, 3'd2, 3'd0, 3'd4, 3'd1, 3'd0},
    {3'd2, 3'd2, 3'd2, 3'd4, 3'd3, 3'd2},
    {3'd2, 3'd2, 3'd2, 3'd0, 3'd2, 3'd3},
    {3'd2, 3'd2, 3'd2, 3'd2, 3'd0, 3'd4},
    {3'd0, 3'd0, 3'd0, 3'd0, 3'd4, 3'd4},
    {3'd4, 3'd4, 3'd3, 3'd4, 3'd4, 3'd0},
    {3'd1, 3'd3, 3'd1, 3'd0, 3'd0, 3'd3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_in();
    fwd_vld_i = '0; fwd_hdr_i = '0; fwd_dst_i = '0;
    bwd_vld_i = '0; bwd_hdr_i = '0;
  endtask

  task automatic put_fwd(input int p, input logic [2:0] h, input logic [2:0] x, input logic [2:0] y);
    fwd_vld_i[p] = 1'b1;
    fwd_hdr_i[p*3 +: 3] = h;
    fwd_dst_i[p*6 +: 6] = {x, y};
  endtask

  task automatic put_bwd(input int p, input logic [2:0] h);
    bwd_vld_i[p] = 1'b1;
    bwd_hdr_i[p*3 +: 3] = h;
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic chk_fwd(input string tag, input logic [4:0] mask);
    chk(fwd_vld_o == mask, tag, int'(fwd_vld_o), int'(mask));
  endtask

  task automatic chk_bwd(input string tag, input logic [4:0] mask);
    chk(bwd_vld_o == mask, tag, int'(bwd_vld_o), int'(mask));
  endtask

  task automatic chk_fhdr(input string tag, input int p, input logic [2:0] h);
    chk(fwd_hdr_o[p*3 +: 3] == h, tag, int'(fwd_hdr_o[p*3 +: 3]), int'(h));
  endtask

  task automatic chk_bhdr(input string tag, input int p, input logic [2:0] h);
    chk(bwd_hdr_o[p*3 +: 3] == h, tag, int'(bwd_hdr_o[p*3 +: 3]), int'(h));
  endtask

  task automatic chk_err(input string tag, input logic e);
    chk(err_o == e, tag, int'(err_o), int'(e));
  endtask

  initial begin
    my_x_i = 3'd2; my_y_i = 3'd2;
    clr_in();
    repeat (3) step();
    // R11 outputs held low during reset
    chk_fwd("R11 fwd in reset", 5'b0);
    chk_bwd("R11 bwd in reset", 5'b0);
    rst_ni = 1'b1;
    step();
    chk_err("R11 err after reset", 1'b0);
    chk_fwd("R11 fwd after reset", 5'b0);

    // routing vectors: request, then tear down with a kill
    for (int k = 0; k < 8; k++) begin
      logic [2:0] mx, my, dx, dy, pin, pout;
      {mx, my, dx, dy, pin, pout} = VEC[k];
      my_x_i = mx; my_y_i = my;
      put_fwd(int'(pin), REQ, dx, dy);
      step();
      chk_fwd("R2 output port", 5'(1 << pout));
      chk_fhdr("R3 forwarded header", int'(pout), REQ);
      chk(fwd_dst_o[pout*6 +: 6] == {dx, dy}, "R3 forwarded dest",
          int'(fwd_dst_o[pout*6 +: 6]), int'({dx, dy}));
      chk_err("R3 no error", 1'b0);
      clr_in();
      put_bwd(int'(pout), KILL);
      step();
      chk_bwd("R9 kill returned", 5'(1 << pin));
      chk_bhdr("R9 kill header", int'(pin), KILL);
      clr_in();
    end

    my_x_i = 3'd2; my_y_i = 3'd2;
    // route W -> E
    put_fwd(W, REQ, 3'd4, 3'd2); step();
    chk_fwd("R3 route W to E", 5'b00010); clr_in();
    // R4 busy output
    put_fwd(L, REQ, 3'd4, 3'd0); step();
    chk_fwd("R4 no forward when busy", 5'b0);
    chk_bwd("R4 kill to source", 5'b10000);
    chk_bhdr("R4 kill header", L, KILL); clr_in();
    // R6 ack back, table kept
    put_bwd(E, ACK); step();
    chk_bwd("R6 ack to W", 5'b00001);
    chk_bhdr("R6 ack header", W, ACK); clr_in();
    put_fwd(N, REQ, 3'd3, 3'd1); step();
    chk_bwd("R6 route kept after ack", 5'b00100); clr_in();
    // R7 release forward
    put_fwd(W, REL, 3'd0, 3'd0); step();
    chk_fwd("R7 rel to E", 5'b00010);
    chk_fhdr("R7 rel header", E, REL);
    chk(fwd_dst_o[E*6 +: 6] == 6'd0, "R7 rel dest zero", int'(fwd_dst_o[E*6 +: 6]), 0); clr_in();
    // R10 unmatched messages
    put_fwd(N, REL, 3'd0, 3'd0); step();
    chk_err("R10 rel without route", 1'b1);
    chk_fwd("R10 rel dropped", 5'b0); clr_in();
    put_fwd(W, REQ, 3'd2, 3'd4); step();
    chk_err("R10 req on owning input", 1'b1);
    chk_fwd("R10 req dropped fwd", 5'b0);
    chk_bwd("R10 req dropped bwd", 5'b0); clr_in();
    put_bwd(S, ACK); step();
    chk_err("R10 ack on free output", 1'b1);
    chk_bwd("R10 ack dropped", 5'b0); clr_in();
    step();
    chk_err("R10 err is one pulse", 1'b0);
    // R8 release ack frees; R4 same-cycle request still killed
    put_bwd(E, RELB); put_fwd(L, REQ, 3'd4, 3'd2); step();
    chk_bwd("R8 relb plus R4 kill", 5'b10001);
    chk_bhdr("R8 relb header", W, RELB);
    chk_bhdr("R4 same cycle kill", L, KILL);
    chk_fwd("R4 no forward same cycle", 5'b0); clr_in();
    put_fwd(L, REQ, 3'd4, 3'd2); step();
    chk_fwd("R8 output freed", 5'b00010); clr_in();
    put_bwd(E, KILL); step();
    chk_bwd("R9 kill to L", 5'b10000); clr_in();
    // R5 three-way contention for E
    put_fwd(W, REQ, 3'd4, 3'd2);
    put_fwd(N, REQ, 3'd3, 3'd1);
    put_fwd(L, REQ, 3'd4, 3'd4);
    step();
    chk_fwd("R5 single winner", 5'b00010);
    chk(fwd_dst_o[E*6 +: 6] == 6'b100_010, "R5 lowest index dest",
        int'(fwd_dst_o[E*6 +: 6]), int'(6'b100_010));
    chk_bwd("R5 losers killed", 5'b10100); clr_in();
    put_bwd(E, KILL); step();
    chk_bwd("R5 winner owned E", 5'b00001); clr_in();
    // R1 wrong header on a lane
    put_fwd(W, ACK, 3'd0, 3'd0); step();
    chk_err("R1 ack on fwd lane", 1'b1);
    chk_bwd("R1 dropped", 5'b0); clr_in();
    put_bwd(S, REQ); step();
    chk_err("R1 req on bwd lane", 1'b1);
    chk_fwd("R1 dropped fwd", 5'b0); clr_in();
    // R11 reset clears the table
    put_fwd(W, REQ, 3'd4, 3'd2); step(); clr_in();
    rst_ni = 1'b0; step(); rst_ni = 1'b1; step();
    put_fwd(L, REQ, 3'd4, 3'd2); step();
    chk_fwd("R11 table empty after reset", 5'b00010); clr_in();
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule